// File: doc/BRIEF.md
# Floppy Head Stepper Controller

This block positions the read/write head of the currently selected floppy drive. A seek request carries a target track. The block compares that target with its own record of the current track and sets the direction line. It then issues one timed step pulse per track until the difference is used up. A fixed settle time follows, and a one-cycle completion strobe ends the operation. A recalibrate request drives the head outward until the track-zero sensor reports. The number of outward steps is bounded by the track count. After a recalibrate, the track record reads zero.

All intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter: the step pulse width, the spacing between pulse starts, and the settle time. A step pulse is started only while the drive reports its head as loaded. A flag that is registered alongside the track record shows when the head is above the high-track threshold. The write path uses this flag to select the reduced write current.

Top module: `head_stepper`

## Requirements
- R1: After reset, busy, done, the step line and the high-track flag are all 0, and the current track reads 0.
- R2: A seek to a target above the current track sets the direction line to 1 (inward). A seek to a target below it sets the line to 0 (outward). Exactly |target - current| step pulses follow, and the current track then equals the target.
- R3: Every step pulse is high for STEP_PULSE_US converted to clock cycles.
- R4: Within one operation, consecutive step pulses start exactly STEP_GAP_US apart, in clock cycles.
- R5: The direction line is set in the cycle a request is accepted and holds steady until busy falls. The first pulse starts one full step spacing after acceptance.
- R6: done is a single-cycle pulse, asserted in the cycle busy falls. After the final pulse of a seek ends, it comes SETTLE_US later, in clock cycles.
- R7: A seek whose target equals the current track issues no pulse. Its done still follows the settle time, counted from acceptance.
- R8: A recalibrate steps outward (direction 0) and tests the track-zero sensor before each pulse. Once the sensor reads 1, stepping stops, the current track becomes 0 and the settle time runs. If the sensor already reads 1 at the request, no pulse is issued.
- R9: If the sensor never reports, a recalibrate issues exactly NUM_TRACKS-1 pulses, and the current track then reads 0.
- R10: A step pulse starts only if head_loaded was 1 in the preceding cycle. While head_loaded is 0, the block waits with the step line low.
- R11: high_trk is 1 exactly when the current track exceeds HIGH_TRACK, and it changes in the same cycle as the track.
- R12: Requests arriving while busy have no effect. When seek and recalibrate arrive in the same idle cycle, the recalibrate is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| seek_req | input | 1 | Start a seek to target_trk (sampled while idle) |
| recal_req | input | 1 | Start a recalibrate (sampled while idle, wins over seek_req) |
| target_trk | input | TRK_W | Destination track for a seek |
| head_loaded | input | 1 | Selected drive reports its head loaded |
| trk0_sense | input | 1 | Track-zero sensor, 1 when the head is at the outermost track |
| step_dir | output | 1 | Step direction, 1 inward (rising track), 0 outward |
| step_pulse | output | 1 | Step pulse to the drive |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| cur_trk | output | TRK_W | Track the head is believed to sit on |
| high_trk | output | 1 | Current track above HIGH_TRACK |

## Verification
The hardest state to reach is a recalibrate that never finds the track-zero sensor, so that the step bound alone ends it. A drive model in the bench tracks the physical head position from the pulses and drives the sensor from it. Before one recalibrate, the bench first seeks far inward and then holds the sensor inactive, forcing all NUM_TRACKS-1 pulses. The sensor is then released, and a further recalibrate checks the case where the sensor is already active at the request. The stall while the head is unloaded is reached by dropping head_loaded before a seek and confirming that the step line stays low past the first spacing interval.

// File: rtl/head_stepper_pkg.sv
package head_stepper_pkg;
  typedef enum logic [2:0] {
    HS_IDLE,
    HS_AIM,
    HS_PULSE,
    HS_GAP,
    HS_SETTLE
  } hs_state_e;
endpackage

// File: rtl/hs_timer.sv
// Down-counter: load a value, then it counts to zero and holds there.
module hs_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/hs_track.sv
// Current-track register with saturating step and the high-track flag.
module hs_track #(
  parameter int unsigned TRK_W      = 7,
  parameter int unsigned HIGH_TRACK = 43
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             step_inc,
  input  logic             clear,
  output logic [TRK_W-1:0] cur_trk,
  output logic             high_trk
);
  logic [TRK_W-1:0] trk_nxt;

  always_comb begin
    trk_nxt = cur_trk;
    if (clear) begin
      trk_nxt = '0;
    end else if (step_en) begin
      if (step_inc) trk_nxt = (cur_trk == '1) ? cur_trk : cur_trk + 1'b1;
      else          trk_nxt = (cur_trk == '0) ? cur_trk : cur_trk - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_trk  <= '0;
      high_trk <= 1'b0;
    end else begin
      cur_trk  <= trk_nxt;
      high_trk <= (trk_nxt > TRK_W'(HIGH_TRACK));
    end
  end
endmodule

// File: rtl/hs_seq.sv
// Operation sequencer: aim, pulse, gap, settle.
module hs_seq
  import head_stepper_pkg::*;
#(
  parameter int unsigned TRK_W       = 7,
  parameter int unsigned TW          = 16,
  parameter int unsigned PULSE_CYC   = 2,
  parameter int unsigned GAP_CYC     = 200,
  parameter int unsigned SETTLE_CYC  = 400,
  parameter int unsigned RECAL_STEPS = 76
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seek_req,
  input  logic             recal_req,
  input  logic [TRK_W-1:0] target,
  input  logic [TRK_W-1:0] cur_trk,
  input  logic             head_loaded,
  input  logic             trk0,
  input  logic             t_expired,
  output logic             t_load,
  output logic [TW-1:0]    t_val,
  output logic             trk_step,
  output logic             trk_inc,
  output logic             trk_clear,
  output logic             busy,
  output logic             step_out,
  output logic             dir_out,
  output logic             done_out
);
  localparam logic [TW-1:0]    L_AIM    = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0]    L_PULSE  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0]    L_WAIT   = TW'(GAP_CYC - PULSE_CYC - 1);
  localparam logic [TW-1:0]    L_SETTLE = TW'(SETTLE_CYC - 1);
  localparam logic [TRK_W-1:0] R_STEPS  = TRK_W'(RECAL_STEPS);

  hs_state_e        st, st_n;
  logic [TRK_W-1:0] rem, rem_n;
  logic             dir_q, dir_n;
  logic             rec_q, rec_n;
  logic             done_q, done_n;

  always_comb begin
    st_n      = st;
    rem_n     = rem;
    dir_n     = dir_q;
    rec_n     = rec_q;
    done_n    = 1'b0;
    t_load    = 1'b0;
    t_val     = '0;
    trk_step  = 1'b0;
    trk_inc   = dir_q;
    trk_clear = 1'b0;
    case (st)
      HS_IDLE: begin
        if (recal_req) begin
          rec_n  = 1'b1;
          dir_n  = 1'b0;
          rem_n  = R_STEPS;
          t_load = 1'b1;
          if (trk0) begin
            trk_clear = 1'b1;
            st_n      = HS_SETTLE;
            t_val     = L_SETTLE;
          end else begin
            st_n  = HS_AIM;
            t_val = L_AIM;
          end
        end else if (seek_req) begin
          rec_n  = 1'b0;
          t_load = 1'b1;
          if (target > cur_trk) begin
            dir_n = 1'b1;
            rem_n = target - cur_trk;
            st_n  = HS_AIM;
            t_val = L_AIM;
          end else if (target < cur_trk) begin
            dir_n = 1'b0;
            rem_n = cur_trk - target;
            st_n  = HS_AIM;
            t_val = L_AIM;
          end else begin
            st_n  = HS_SETTLE;
            t_val = L_SETTLE;
          end
        end
      end
      HS_AIM, HS_GAP: begin
        if (t_expired) begin
          if (rec_q && trk0) begin
            trk_clear = 1'b1;
            st_n      = HS_SETTLE;
            t_load    = 1'b1;
            t_val     = L_SETTLE;
          end else if (head_loaded) begin
            st_n   = HS_PULSE;
            t_load = 1'b1;
            t_val  = L_PULSE;
          end
        end
      end
      HS_PULSE: begin
        if (t_expired) begin
          trk_step = 1'b1;
          rem_n    = rem - 1'b1;
          t_load   = 1'b1;
          if (rem == TRK_W'(1)) begin
            trk_clear = rec_q;
            st_n      = HS_SETTLE;
            t_val     = L_SETTLE;
          end else begin
            st_n  = HS_GAP;
            t_val = L_WAIT;
          end
        end
      end
      HS_SETTLE: begin
        if (t_expired) begin
          st_n   = HS_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= HS_IDLE;
      rem    <= '0;
      dir_q  <= 1'b0;
      rec_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_n;
      rem    <= rem_n;
      dir_q  <= dir_n;
      rec_q  <= rec_n;
      done_q <= done_n;
    end
  end

  assign busy     = (st != HS_IDLE);
  assign step_out = (st == HS_PULSE);
  assign dir_out  = dir_q;
  assign done_out = done_q;
endmodule

// File: rtl/head_stepper.sv
module head_stepper #(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned STEP_PULSE_US = 10,
  parameter int unsigned STEP_GAP_US   = 10_000,
  parameter int unsigned SETTLE_US     = 20_000,
  parameter int unsigned NUM_TRACKS    = 77,
  parameter int unsigned HIGH_TRACK    = 43,
  localparam int unsigned TRK_W        = $clog2(NUM_TRACKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seek_req,
  input  logic             recal_req,
  input  logic [TRK_W-1:0] target_trk,
  input  logic             head_loaded,
  input  logic             trk0_sense,
  output logic             step_dir,
  output logic             step_pulse,
  output logic             busy,
  output logic             done,
  output logic [TRK_W-1:0] cur_trk,
  output logic             high_trk
);
  localparam longint unsigned P_RAW = (64'(CLK_HZ) * 64'(STEP_PULSE_US)) / 64'd1_000_000;
  localparam longint unsigned G_RAW = (64'(CLK_HZ) * 64'(STEP_GAP_US))   / 64'd1_000_000;
  localparam longint unsigned S_RAW = (64'(CLK_HZ) * 64'(SETTLE_US))     / 64'd1_000_000;
  localparam int unsigned PULSE_CYC  = (P_RAW == 64'd0) ? 1 : 32'(P_RAW);
  localparam int unsigned GAP_CYC    = (G_RAW <= 64'(PULSE_CYC)) ? PULSE_CYC + 1 : 32'(G_RAW);
  localparam int unsigned SETTLE_CYC = (S_RAW == 64'd0) ? 1 : 32'(S_RAW);
  localparam int unsigned MAX_CYC    = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int unsigned TW         = $clog2(MAX_CYC + 1);

  logic          t_load, t_expired;
  logic [TW-1:0] t_val;
  logic          trk_step, trk_inc, trk_clear;

  hs_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  hs_track #(.TRK_W(TRK_W), .HIGH_TRACK(HIGH_TRACK)) u_track (
    .clk      (clk),
    .rst      (rst),
    .step_en  (trk_step),
    .step_inc (trk_inc),
    .clear    (trk_clear),
    .cur_trk  (cur_trk),
    .high_trk (high_trk)
  );

  hs_seq #(
    .TRK_W       (TRK_W),
    .TW          (TW),
    .PULSE_CYC   (PULSE_CYC),
    .GAP_CYC     (GAP_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .RECAL_STEPS (NUM_TRACKS - 1)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .seek_req    (seek_req),
    .recal_req   (recal_req),
    .target      (target_trk),
    .cur_trk     (cur_trk),
    .head_loaded (head_loaded),
    .trk0        (trk0_sense),
    .t_expired   (t_expired),
    .t_load      (t_load),
    .t_val       (t_val),
    .trk_step    (trk_step),
    .trk_inc     (trk_inc),
    .trk_clear   (trk_clear),
    .busy        (busy),
    .step_out    (step_pulse),
    .dir_out     (step_dir),
    .done_out    (done)
  );
endmodule

// File: rtl/head_stepper_chk.sv
module head_stepper_chk #(
  parameter int unsigned TRK_W      = 7,
  parameter int unsigned PULSE_CYC  = 2,
  parameter int unsigned GAP_CYC    = 200,
  parameter int unsigned HIGH_TRACK = 43
) (
  input logic             clk,
  input logic             rst,
  input logic             head_loaded,
  input logic             step_dir,
  input logic             step_pulse,
  input logic             busy,
  input logic             done,
  input logic [TRK_W-1:0] cur_trk,
  input logic             high_trk
);
  logic [31:0] hi_cnt;
  logic [31:0] sp_cnt;
  logic        step_d;
  logic        armed;
  logic        rise_now;

  assign rise_now = step_pulse && !step_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      sp_cnt <= '0;
      step_d <= 1'b0;
      armed  <= 1'b0;
    end else begin
      step_d <= step_pulse;
      hi_cnt <= step_pulse ? hi_cnt + 1 : '0;
      if (rise_now)          sp_cnt <= 32'd1;
      else if (sp_cnt != '1) sp_cnt <= sp_cnt + 1;
      if (!busy)             armed <= 1'b0;
      else if (rise_now)     armed <= 1'b1;
    end
  end

  // R3
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(step_pulse) |-> hi_cnt == PULSE_CYC);
  // R4
  a_r4_step_spacing: assert property (@(posedge clk) disable iff (rst)
    (rise_now && armed) |-> sp_cnt == GAP_CYC);
  // R5
  a_r5_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(step_dir));
  // R10
  a_r10_head_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(step_pulse) |-> $past(head_loaded));
  // R11
  a_r11_high_flag: assert property (@(posedge clk) disable iff (rst)
    high_trk == (cur_trk > TRK_W'(HIGH_TRACK)));
  // R6
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R12
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !step_pulse);
endmodule

bind head_stepper head_stepper_chk #(
  .TRK_W      (TRK_W),
  .PULSE_CYC  (PULSE_CYC),
  .GAP_CYC    (GAP_CYC),
  .HIGH_TRACK (HIGH_TRACK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .head_loaded (head_loaded),
  .step_dir    (step_dir),
  .step_pulse  (step_pulse),
  .busy        (busy),
  .done        (done),
  .cur_trk     (cur_trk),
  .high_trk    (high_trk)
);

// File: tb/head_stepper_test.sv
module head_stepper_test;
  localparam int CLK_HZ = 200_000;
  localparam int PUS    = 10;
  localparam int GUS    = 1000;
  localparam int SUS    = 2000;
  localparam int NT     = 77;
  localparam int HT     = 43;
  localparam int P      = CLK_HZ / 1000 * PUS / 1000;
  localparam int G      = CLK_HZ / 1000 * GUS / 1000;
  localparam int S      = CLK_HZ / 1000 * SUS / 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seek_req = 1'b0;
  logic       recal_req = 1'b0;
  logic [6:0] target_trk = '0;
  logic       head_loaded = 1'b1;
  logic       trk0_sense;
  logic       step_dir, step_pulse, busy, done, high_trk;
  logic [6:0] cur_trk;

  always #10 clk = ~clk;

  head_stepper #(
    .CLK_HZ(CLK_HZ), .STEP_PULSE_US(PUS), .STEP_GAP_US(GUS),
    .SETTLE_US(SUS), .NUM_TRACKS(NT), .HIGH_TRACK(HT)
  ) uut (
    .clk(clk), .rst(rst), .seek_req(seek_req), .recal_req(recal_req),
    .target_trk(target_trk), .head_loaded(head_loaded), .trk0_sense(trk0_sense),
    .step_dir(step_dir), .step_pulse(step_pulse), .busy(busy), .done(done),
    .cur_trk(cur_trk), .high_trk(high_trk)
  );

  typedef struct {
    int    steps;
    bit    dir;
    int    fin;
    bit    chk_first;
    int    tail;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0, busy_start = 0, last_rise = 0, last_fall = 0, nsteps = 0, dones = 0;
  bit   busy_q = 0, step_q = 0, trk0_broken = 0, ended = 0;
  int   phys = 0;
  int   model = 0;

  assign trk0_sense = (phys == 0) && !trk0_broken;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: drive model, timing checks, scoreboard compare.
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (busy && !busy_q) begin
        busy_start = cyc;
        nsteps = 0;
      end
      if (step_pulse && !step_q) begin
        nsteps++;
        if (sbq.size() > 0) begin
          check(step_dir == sbq[0].dir, {sbq[0].tag, " direction"}, step_dir, sbq[0].dir);
          if (nsteps == 1 && sbq[0].chk_first)
            check(cyc - busy_start == G, "R5 first pulse delay", cyc - busy_start, G);
        end
        if (nsteps > 1) check(cyc - last_rise == G, "R4 pulse spacing", cyc - last_rise, G);
        check(head_loaded, "R10 pulse with head loaded", head_loaded, 1);
        if (step_dir) phys++;
        else if (phys > 0) phys--;
        last_rise = cyc;
      end
      if (!step_pulse && step_q) begin
        check(cyc - last_rise == P, "R3 pulse width", cyc - last_rise, P);
        last_fall = cyc;
      end
      if (done) begin
        dones++;
        if (sbq.size() == 0) begin
          check(0, "R12 unexpected done", 1, 0);
        end else begin
          exp_t e;
          int   ref_c;
          e = sbq.pop_front();
          check(nsteps == e.steps, {e.tag, " step count"}, nsteps, e.steps);
          check(int'(cur_trk) == e.fin, {e.tag, " final track"}, cur_trk, e.fin);
          check(high_trk == (e.fin > HT), "R11 high flag", high_trk, e.fin > HT);
          check(!busy, "R6 busy low with done", busy, 0);
          ref_c = (e.steps == 0) ? busy_start : last_fall;
          check(cyc - ref_c == e.tail, {e.tag, " settle timing"}, cyc - ref_c, e.tail);
        end
      end
      busy_q = busy;
      step_q = step_pulse;
    end
  end

  task automatic pulse_req(input bit rec, input bit sk, input int tgt);
    @(negedge clk);
    recal_req  = rec;
    seek_req   = sk;
    target_trk = 7'(tgt);
    @(negedge clk);
    recal_req = 1'b0;
    seek_req  = 1'b0;
  endtask

  task automatic wait_done(input int n0);
    while (dones <= n0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_seek(input int tgt, input bit chk_first, input string tag);
    exp_t e;
    e.steps = (tgt > model) ? tgt - model : model - tgt;
    e.dir = (tgt > model);
    e.fin = tgt;
    e.chk_first = chk_first;
    e.tail = S;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic seek(input int tgt, input string tag);
    int n0;
    n0 = dones;
    push_seek(tgt, 1, tag);
    pulse_req(0, 1, tgt);
    wait_done(n0);
    model = tgt;
  endtask

  task automatic recal(input int steps, input int tail, input bit also_seek, input string tag);
    exp_t e;
    int   n0;
    n0 = dones;
    e.steps = steps;
    e.dir = 0;
    e.fin = 0;
    e.chk_first = 1;
    e.tail = tail;
    e.tag = tag;
    sbq.push_back(e);
    pulse_req(1, also_seek, 30);
    wait_done(n0);
    model = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1 busy after reset", busy, 0);
    check(!done, "R1 done after reset", done, 0);
    check(!step_pulse, "R1 step after reset", step_pulse, 0);
    check(cur_trk == 0, "R1 track after reset", cur_trk, 0);
    check(!high_trk, "R1 high flag after reset", high_trk, 0);

    seek(10, "R2 inward seek");

    // R12: request while busy is ignored
    begin
      int n0;
      n0 = dones;
      push_seek(50, 1, "R2 long inward seek");
      pulse_req(0, 1, 50);
      repeat (500) @(negedge clk);
      pulse_req(0, 1, 70);
      pulse_req(1, 0, 0);
      wait_done(n0);
      model = 50;
      repeat (20) @(negedge clk);
      check(sbq.size() == 0 && !busy, "R12 busy request ignored", busy, 0);
      check(cur_trk == 50, "R12 track unchanged by ignored request", cur_trk, 50);
    end

    seek(50, "R7 zero-distance seek");
    seek(44, "R2 outward seek");
    seek(43, "R11 drop below threshold");
    recal(43, G - P + S, 0, "R8 recal stops at sensor");

    seek(5, "R2 short seek");
    recal(5, G - P + S, 1, "R12 recal wins over seek");

    // R10: head unloaded stalls stepping
    begin
      int n0;
      n0 = dones;
      head_loaded = 1'b0;
      push_seek(60, 0, "R10 delayed seek");
      pulse_req(0, 1, 60);
      repeat (G + 300) @(negedge clk);
      check(nsteps == 0 && !step_pulse && busy, "R10 no pulse while unloaded", nsteps, 0);
      head_loaded = 1'b1;
      wait_done(n0);
      model = 60;
    end

    trk0_broken = 1;
    recal(NT - 1, S, 0, "R9 recal step bound");
    check(phys == 0, "R9 head reached outer stop", phys, 0);
    trk0_broken = 0;
    recal(0, S, 0, "R8 recal at track zero");

    repeat (10) @(negedge clk);
    check(sbq.size() == 0, "R6 all operations completed", sbq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule